// File: doc/BRIEF.md
# Tagged Register Ownership Table

This block keeps the architectural register state of a tag-based out-of-order core. For every architectural register it holds a data value and an owner tag. The owner tag names the station that will produce the next value for that register. A tag of zero means the stored value is current. Two read ports serve the instruction being issued. Each port returns either a ready value or the tag of the pending producer. An issue strobe hands ownership of the destination register to the issuing station.

Finishing units raise a request that carries a tag and a value. A round-robin arbiter grants one of them per cycle onto the result bus. The table listens to that bus and writes a value only into registers that the broadcast tag still owns. As a result, an older producer that finishes after a newer writer has claimed the register is dropped without any effect. A read port that asks for a register whose producer is on the bus in that same cycle receives the bus value directly. Issue order is kept by whoever drives the issue strobe: a stalled instruction is simply not strobed.

Top module: `tag_regstat`

## Requirements
- R1: After reset, every register reads as ready with value 0 and tag 0.
- R2: A read port is combinational and does not depend on `iss_valid`. It reflects the state before any update in the current cycle. If the selected register's owner tag is 0, the port gives ready=1, the stored value and tag=0. If the owner tag is non-zero, the port gives ready=0, value=0 and the owner tag.
- R3: When `iss_valid` is high, the register `iss_dst` is owned by `iss_tag` from the next cycle on. When `iss_valid` is low, no owner tag changes because of issue.
- R4: A broadcast with a non-zero tag writes its value into every register whose owner equals that tag, and clears those owners to 0 at the next edge.
- R5: A broadcast whose tag is 0, or whose tag owns no register, changes no register value and no owner tag.
- R6: If an issue and a matching broadcast hit the same register in the same cycle, the register is owned by the new `iss_tag` afterwards.
- R7: At most one grant is high per cycle, and only to a requesting unit. `cdb_valid` is high exactly when some unit requests. `cdb_tag` and `cdb_val` are the granted unit's tag and value.
- R8: Round-robin order applies. After unit i is granted, the search starts at unit i+1 and wraps around. Unit 0 has first priority after reset. A unit holds its request until it is granted.
- R9: If a read port selects a register whose non-zero owner equals the tag being broadcast in that cycle, the port returns ready=1 with the broadcast value and tag=0.
- R10: When a register has been re-issued to a newer tag, a later broadcast of the older tag leaves its value and owner untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue strobe for the current instruction |
| iss_dst | input | RW | Destination register of the issued instruction |
| iss_tag | input | TAGW | Tag of the issuing station (non-zero) |
| src_a_sel | input | RW | Register selected by read port A |
| src_b_sel | input | RW | Register selected by read port B |
| src_a_ready | output | 1 | Port A holds a value |
| src_a_val | output | XLEN | Port A value (0 when not ready) |
| src_a_tag | output | TAGW | Port A producer tag (0 when ready) |
| src_b_ready | output | 1 | Port B holds a value |
| src_b_val | output | XLEN | Port B value (0 when not ready) |
| src_b_tag | output | TAGW | Port B producer tag (0 when ready) |
| fin_req | input | NUNIT | Per-unit result request |
| fin_tag | input | NUNIT*TAGW | Per-unit result tags, unit u at bits u*TAGW |
| fin_val | input | NUNIT*XLEN | Per-unit result values, unit u at bits u*XLEN |
| fin_gnt | output | NUNIT | Per-unit grant |
| cdb_valid | output | 1 | Broadcast present this cycle |
| cdb_tag | output | TAGW | Broadcast tag |
| cdb_val | output | XLEN | Broadcast value |

## Verification
Suppose an owner tag is wrong inside the table. Then the next read of that register returns the wrong ready flag or tag in the same cycle. The fault can also surface when the owning tag is broadcast: the register either fails to turn ready or picks up a value it should have ignored. The arbiter pointer is visible at once through the grant pattern whenever two or more units are requesting. The bench therefore compares both read ports and the whole bus against a reference model on every cycle. It also sweeps every register after each corner case, so a corrupted entry shows up within a few cycles.

// File: rtl/tag_regstat_pkg.sv
package tag_regstat_pkg;

  // index a+b reduced into range 0..n-1, assuming a,b < n
  function automatic int wrap_add(int a, int b, int n);
    int s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction

  // a broadcast claims a register when its tag is real and equals the owner
  function automatic logic tag_claims(logic [7:0] owner, logic [7:0] btag, logic bvalid);
    return bvalid && (btag != 8'd0) && (owner == btag);
  endfunction

endpackage

// File: rtl/cdb_rr_arb.sv
module cdb_rr_arb
  import tag_regstat_pkg::*;
#(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gidx,
  output logic          any
);

  logic [IW-1:0] ptr_q;

  always_comb begin
    gnt  = '0;
    gidx = '0;
    any  = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!any && req[wrap_add(int'(ptr_q), k, N)]) begin
        any = 1'b1;
        gnt[wrap_add(int'(ptr_q), k, N)] = 1'b1;
        gidx = IW'(wrap_add(int'(ptr_q), k, N));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (any) ptr_q <= IW'(wrap_add(int'(gidx), 1, N));
  end

endmodule

// File: rtl/own_table.sv
module own_table
  import tag_regstat_pkg::*;
#(
  parameter int NREG = 8,
  parameter int TAGW = 3,
  parameter int XLEN = 16,
  localparam int RW = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_valid,
  input  logic [RW-1:0]             iss_dst,
  input  logic [TAGW-1:0]           iss_tag,
  input  logic                      bc_valid,
  input  logic [TAGW-1:0]           bc_tag,
  input  logic [XLEN-1:0]           bc_val,
  output logic [NREG-1:0][TAGW-1:0] stat_q,
  output logic [NREG-1:0][XLEN-1:0] val_q,
  output logic [NREG-1:0]           wb_hit,
  output logic [NREG-1:0]           own_hit
);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [TAGW-1:0] st_r;
    logic [XLEN-1:0] vl_r;

    assign own_hit[r] = iss_valid && (iss_dst == RW'(r));
    assign wb_hit[r]  = tag_claims(8'(st_r), 8'(bc_tag), bc_valid);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r <= '0;
        vl_r <= '0;
      end else begin
        if (wb_hit[r])       vl_r <= bc_val;
        if (own_hit[r])      st_r <= iss_tag;   // new owner beats the clear
        else if (wb_hit[r])  st_r <= '0;
      end
    end

    assign stat_q[r] = st_r;
    assign val_q[r]  = vl_r;
  end

endmodule

// File: rtl/src_port.sv
module src_port
  import tag_regstat_pkg::*;
#(
  parameter int NREG = 8,
  parameter int TAGW = 3,
  parameter int XLEN = 16,
  localparam int RW = $clog2(NREG)
) (
  input  logic [RW-1:0]             sel,
  input  logic [NREG-1:0][TAGW-1:0] stat_q,
  input  logic [NREG-1:0][XLEN-1:0] val_q,
  input  logic                      bc_valid,
  input  logic [TAGW-1:0]           bc_tag,
  input  logic [XLEN-1:0]           bc_val,
  output logic                      rdy,
  output logic [XLEN-1:0]           val,
  output logic [TAGW-1:0]           tag,
  output logic                      fwd
);

  logic [TAGW-1:0] own;

  always_comb begin
    own = stat_q[sel];
    fwd = tag_claims(8'(own), 8'(bc_tag), bc_valid);
    if (own == '0) begin
      rdy = 1'b1;
      val = val_q[sel];
      tag = '0;
    end else if (fwd) begin
      rdy = 1'b1;
      val = bc_val;
      tag = '0;
    end else begin
      rdy = 1'b0;
      val = '0;
      tag = own;
    end
  end

endmodule

// File: rtl/tag_regstat.sv
module tag_regstat
  import tag_regstat_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int TAGW  = 3,
  parameter int XLEN  = 16,
  parameter int NUNIT = 3,
  localparam int RW = $clog2(NREG),
  localparam int UW = (NUNIT > 1) ? $clog2(NUNIT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  iss_valid,
  input  logic [RW-1:0]         iss_dst,
  input  logic [TAGW-1:0]       iss_tag,
  input  logic [RW-1:0]         src_a_sel,
  input  logic [RW-1:0]         src_b_sel,
  output logic                  src_a_ready,
  output logic [XLEN-1:0]       src_a_val,
  output logic [TAGW-1:0]       src_a_tag,
  output logic                  src_b_ready,
  output logic [XLEN-1:0]       src_b_val,
  output logic [TAGW-1:0]       src_b_tag,
  input  logic [NUNIT-1:0]      fin_req,
  input  logic [NUNIT*TAGW-1:0] fin_tag,
  input  logic [NUNIT*XLEN-1:0] fin_val,
  output logic [NUNIT-1:0]      fin_gnt,
  output logic                  cdb_valid,
  output logic [TAGW-1:0]       cdb_tag,
  output logic [XLEN-1:0]       cdb_val
);

  // named internal events, watched by the bound checker
  logic [NREG-1:0][TAGW-1:0] stat_q;
  logic [NREG-1:0][XLEN-1:0] val_q;
  logic [NREG-1:0]           wb_hit;
  logic [NREG-1:0]           own_hit;
  logic                      fwd_a;
  logic                      fwd_b;
  logic [UW-1:0]             gnt_idx;

  cdb_rr_arb #(.N(NUNIT)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (fin_req),
    .gnt  (fin_gnt),
    .gidx (gnt_idx),
    .any  (cdb_valid)
  );

  always_comb begin
    cdb_tag = '0;
    cdb_val = '0;
    for (int u = 0; u < NUNIT; u++) begin
      if (fin_gnt[u]) begin
        cdb_tag = fin_tag[u*TAGW +: TAGW];
        cdb_val = fin_val[u*XLEN +: XLEN];
      end
    end
  end

  own_table #(.NREG(NREG), .TAGW(TAGW), .XLEN(XLEN)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_valid(iss_valid),
    .iss_dst  (iss_dst),
    .iss_tag  (iss_tag),
    .bc_valid (cdb_valid),
    .bc_tag   (cdb_tag),
    .bc_val   (cdb_val),
    .stat_q   (stat_q),
    .val_q    (val_q),
    .wb_hit   (wb_hit),
    .own_hit  (own_hit)
  );

  src_port #(.NREG(NREG), .TAGW(TAGW), .XLEN(XLEN)) u_src_a (
    .sel(src_a_sel), .stat_q(stat_q), .val_q(val_q),
    .bc_valid(cdb_valid), .bc_tag(cdb_tag), .bc_val(cdb_val),
    .rdy(src_a_ready), .val(src_a_val), .tag(src_a_tag), .fwd(fwd_a)
  );

  src_port #(.NREG(NREG), .TAGW(TAGW), .XLEN(XLEN)) u_src_b (
    .sel(src_b_sel), .stat_q(stat_q), .val_q(val_q),
    .bc_valid(cdb_valid), .bc_tag(cdb_tag), .bc_val(cdb_val),
    .rdy(src_b_ready), .val(src_b_val), .tag(src_b_tag), .fwd(fwd_b)
  );

endmodule

// File: rtl/tag_regstat_chk.sv
module tag_regstat_chk #(
  parameter int NREG  = 8,
  parameter int TAGW  = 3,
  parameter int XLEN  = 16,
  parameter int NUNIT = 3,
  localparam int RW = $clog2(NREG)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      iss_valid,
  input logic [RW-1:0]             iss_dst,
  input logic [TAGW-1:0]           iss_tag,
  input logic                      src_a_ready,
  input logic [XLEN-1:0]           src_a_val,
  input logic [TAGW-1:0]           src_a_tag,
  input logic [NUNIT-1:0]          fin_req,
  input logic [NUNIT-1:0]          fin_gnt,
  input logic                      cdb_valid,
  input logic [XLEN-1:0]           cdb_val,
  input logic [NREG-1:0][TAGW-1:0] stat_q,
  input logic [NREG-1:0][XLEN-1:0] val_q,
  input logic [NREG-1:0]           wb_hit,
  input logic [NREG-1:0]           own_hit,
  input logic                      fwd_a
);

  // R3 R6
  iss_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> stat_q[$past(iss_dst)] == $past(iss_tag));

  for (genvar r = 0; r < NREG; r++) begin : g_wb
    // R4
    wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_hit[r] && !own_hit[r]) |=> (stat_q[r] == '0) && (val_q[r] == $past(cdb_val)));
  end

  // R5
  stale_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && (wb_hit == '0) && !iss_valid) |=> ($stable(stat_q) && $stable(val_q)));

  // R7
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fin_gnt));

  // R7
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_gnt & ~fin_req) == '0);

  // R7
  bus_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid == (fin_req != '0));

  // R9
  fwd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a |-> (src_a_ready && (src_a_val == cdb_val)));

  // R2
  ready_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_a_ready |-> (src_a_tag == '0));

endmodule

bind tag_regstat tag_regstat_chk #(
  .NREG(NREG), .TAGW(TAGW), .XLEN(XLEN), .NUNIT(NUNIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
  .iss_tag(iss_tag), .src_a_ready(src_a_ready), .src_a_val(src_a_val),
  .src_a_tag(src_a_tag), .fin_req(fin_req), .fin_gnt(fin_gnt),
  .cdb_valid(cdb_valid), .cdb_val(cdb_val), .stat_q(stat_q), .val_q(val_q),
  .wb_hit(wb_hit), .own_hit(own_hit), .fwd_a(fwd_a)
);

// File: tb/sim_tag_regstat.sv
`timescale 1ns/1ps
module sim_tag_regstat;
  localparam int NREG = 8, TAGW = 3, XLEN = 16, NUNIT = 3, RW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [RW-1:0] iss_dst = '0, src_a_sel = '0, src_b_sel = '0;
  logic [TAGW-1:0] iss_tag = '0;
  logic src_a_ready, src_b_ready;
  logic [XLEN-1:0] src_a_val, src_b_val;
  logic [TAGW-1:0] src_a_tag, src_b_tag;
  logic [NUNIT-1:0] fin_req = '0;
  logic [NUNIT*TAGW-1:0] fin_tag = '0;
  logic [NUNIT*XLEN-1:0] fin_val = '0;
  logic [NUNIT-1:0] fin_gnt;
  logic cdb_valid;
  logic [TAGW-1:0] cdb_tag;
  logic [XLEN-1:0] cdb_val;

  always #2 clk = ~clk;

  tag_regstat #(.NREG(NREG), .TAGW(TAGW), .XLEN(XLEN), .NUNIT(NUNIT)) u0 (.*);

  int n_cmp = 0, n_bad = 0;
  logic [TAGW-1:0] m_stat [NREG];
  logic [XLEN-1:0] m_val  [NREG];
  int m_ptr = 0;
  int last_eg = -1;
  bit pend [NUNIT];
  logic [TAGW-1:0] ptag [NUNIT];
  logic [XLEN-1:0] pval [NUNIT];

  task automatic check(string rq, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic exp_read(int s, int eg, output int rdy, output int val, output int tag);
    int own;
    own = int'(m_stat[s]);
    if (own == 0) begin rdy = 1; val = int'(m_val[s]); tag = 0; end
    else if (eg >= 0 && int'(fin_tag[eg*TAGW +: TAGW]) == own) begin
      rdy = 1; val = int'(fin_val[eg*XLEN +: XLEN]); tag = 0;
    end else begin rdy = 0; val = 0; tag = own; end
  endtask

  task automatic set_unit(int u, bit rq, int t, int v);
    fin_req[u] = rq;
    fin_tag[u*TAGW +: TAGW] = TAGW'(t);
    fin_val[u*XLEN +: XLEN] = XLEN'(v);
  endtask

  task automatic drive(bit iv, int d, int t, int sa, int sb);
    iss_valid = iv; iss_dst = RW'(d); iss_tag = TAGW'(t);
    src_a_sel = RW'(sa); src_b_sel = RW'(sb);
  endtask

  // called at a falling edge with inputs already applied
  task automatic tick(string rq);
    int eg, r, v, t;
    logic [TAGW-1:0] bt;
    logic [XLEN-1:0] bv;
    bit hb;
    #1;
    eg = -1;
    for (int k = 0; k < NUNIT; k++)
      if (eg < 0 && fin_req[(m_ptr + k) % NUNIT]) eg = (m_ptr + k) % NUNIT;
    check(rq, "fin_gnt", int'(fin_gnt), (eg < 0) ? 0 : (1 << eg));
    check(rq, "cdb_valid", int'(cdb_valid), (eg < 0) ? 0 : 1);
    if (eg >= 0) begin
      check(rq, "cdb_tag", int'(cdb_tag), int'(fin_tag[eg*TAGW +: TAGW]));
      check(rq, "cdb_val", int'(cdb_val), int'(fin_val[eg*XLEN +: XLEN]));
    end
    exp_read(int'(src_a_sel), eg, r, v, t);
    check(rq, "a_ready", int'(src_a_ready), r);
    check(rq, "a_val", int'(src_a_val), v);
    check(rq, "a_tag", int'(src_a_tag), t);
    exp_read(int'(src_b_sel), eg, r, v, t);
    check(rq, "b_ready", int'(src_b_ready), r);
    check(rq, "b_val", int'(src_b_val), v);
    check(rq, "b_tag", int'(src_b_tag), t);
    @(posedge clk);
    bt = (eg >= 0) ? fin_tag[eg*TAGW +: TAGW] : '0;
    bv = (eg >= 0) ? fin_val[eg*XLEN +: XLEN] : '0;
    for (int q = 0; q < NREG; q++) begin
      hb = (eg >= 0) && (bt != '0) && (m_stat[q] == bt);
      if (hb) m_val[q] = bv;
      if (iss_valid && int'(iss_dst) == q) m_stat[q] = iss_tag;
      else if (hb) m_stat[q] = '0;
    end
    if (eg >= 0) m_ptr = (eg + 1) % NUNIT;
    last_eg = eg;
    @(negedge clk);
  endtask

  task automatic sweep(string rq);
    fin_req = '0;
    for (int s = 0; s < NREG; s++) begin
      drive(0, 0, 0, s, NREG - 1 - s);
      tick(rq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int q = 0; q < NREG; q++) begin m_stat[q] = '0; m_val[q] = '0; end
    for (int u = 0; u < NUNIT; u++) pend[u] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    sweep("R1");

    // R3: issue records owner, idle issue strobe changes nothing
    drive(1, 1, 5, 0, 0); tick("R3");
    drive(0, 4, 6, 1, 4); tick("R3");
    drive(0, 0, 0, 4, 1); tick("R3");

    // R10: older writer of r2 broadcasts after re-issue
    drive(1, 2, 1, 2, 2); tick("R10");
    drive(1, 2, 2, 2, 2); tick("R10");
    drive(0, 0, 0, 2, 2); set_unit(0, 1, 1, 'hAAAA); tick("R10");
    set_unit(0, 0, 0, 0); tick("R10");
    // R9: owner of r2 is on the bus this cycle
    set_unit(1, 1, 2, 'h1234); tick("R9");
    set_unit(1, 0, 0, 0); tick("R4");

    // R5: tag owning nothing, then tag zero
    set_unit(2, 1, 7, 'hFFFF); tick("R5");
    set_unit(2, 0, 0, 0);
    sweep("R5");
    set_unit(0, 1, 0, 'h5555); drive(0, 0, 0, 3, 5); tick("R5");
    set_unit(0, 0, 0, 0);
    sweep("R5");

    // R6: issue and clearing broadcast on r3 together
    drive(1, 3, 3, 3, 3); tick("R6");
    drive(1, 3, 4, 3, 3); set_unit(0, 1, 3, 'h3333); tick("R6");
    set_unit(0, 0, 0, 0); drive(0, 0, 0, 3, 1); tick("R6");
    drive(0, 0, 0, 3, 3); set_unit(1, 1, 4, 'h4444); tick("R4");
    set_unit(1, 0, 0, 0); tick("R4");
    drive(0, 0, 0, 1, 3); set_unit(2, 1, 5, 'h5151); tick("R4");
    set_unit(2, 0, 0, 0);

    // R8: all units request and hold until granted
    for (int u = 0; u < NUNIT; u++) begin pend[u] = 1; ptag[u] = TAGW'(u + 1); pval[u] = XLEN'(16 * u + 7); end
    for (int c = 0; c < 4; c++) begin
      for (int u = 0; u < NUNIT; u++) set_unit(u, pend[u], int'(ptag[u]), int'(pval[u]));
      tick("R8");
      if (last_eg >= 0) pend[last_eg] = 0;
    end

    // R2 R7: long mixed run against the model
    void'($urandom(7));
    for (int c = 0; c < 4000; c++) begin
      for (int u = 0; u < NUNIT; u++) begin
        if (!pend[u] && ($urandom % 3 == 0)) begin
          pend[u] = 1; ptag[u] = TAGW'($urandom % 8); pval[u] = XLEN'($urandom);
        end
        set_unit(u, pend[u], int'(ptag[u]), int'(pval[u]));
      end
      drive(($urandom % 2) == 1, int'($urandom % NREG), int'($urandom % 7) + 1,
            int'($urandom % NREG), int'($urandom % NREG));
      tick("R2 R7");
      if (last_eg >= 0) pend[last_eg] = 0;
    end
    sweep("R2");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule